// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits beside one processor core and holds every interrupt that has been handed to that core until the core takes it and finishes with it. Vectors arrive on an accept port together with their trigger mode. They wait in a 256-entry request set. When the core acknowledges, the highest-numbered request moves into a 256-entry in-service set. An end-of-interrupt strobe retires the highest in-service vector.

A four-bit task priority and a processor priority derived from it gate which requests may interrupt the core. The processor priority also depends on the highest in-service vector, and both priorities are compared a class (upper nibble) at a time. A spurious-vector register carries the software enable bit. It also supplies the vector that the core receives when an acknowledge cannot hand over a real one. The interrupt line is a pure function of registered state, so it reacts on the clock after any change. A counter records how many accepted vectors were new to the request set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: An accept with `acc_valid` high sets the request bit of `acc_vec`. It records the trigger mode: level when `acc_level`=1, edge when 0. The trigger mode later appears on `ack_level` when that vector is acknowledged.
- R2: Among pending requests, the highest-numbered vector is the one granted first.
- R3: The spurious register is 9 bits wide. A write keeps bits 8:0 of `reg_wdata`, and reset loads 0x0FF. Bit 8 is the enable: while it is 0, `irq_out` stays low.
- R4: `irq_out` is high when the block is enabled and a request is pending, and either `ppr` is zero or bits 7:4 of the highest request exceed bits 7:4 of `ppr`.
- R5: If the task priority is nonzero and the highest request is numerically at or below it, an acknowledge returns the spurious register's low byte with `ack_spurious`=1 and leaves the request set unchanged.
- R6: Otherwise an acknowledge moves the highest request from the request set to the in-service set. It returns that vector on `ack_vec` with `ack_valid`=1 and `ack_spurious`=0 in the cycle after `ack_req`.
- R7: `eoi` clears the highest set in-service bit. With the in-service set empty it has no effect.
- R8: With `reg_sel`=0, a write stores `reg_wdata[3:0]` into bits 7:4 of the task priority, and a read returns those four bits in `reg_rdata[3:0]`. With `reg_sel`=1, reads and writes reach the spurious register.
- R9: `ppr` equals the task priority when the task priority's class is at least the class of the highest in-service vector. Otherwise `ppr` equals that vector's class with a zero low nibble.
- R10: `new_cnt` increments on an accept only when the vector's request bit was clear beforehand.
- R11: Reset clears the request, in-service and trigger sets, the task priority and `new_cnt`.
- R12: An acknowledge with no pending request, or while disabled, returns the spurious low byte with `ack_spurious`=1 and moves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accept a vector this cycle |
| acc_vec | input | 8 | Vector being accepted |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Core acknowledge strobe |
| ack_valid | output | 1 | Acknowledge reply valid (one cycle after ack_req) |
| ack_vec | output | 8 | Vector handed to the core |
| ack_level | output | 1 | Trigger mode of the granted vector |
| ack_spurious | output | 1 | Reply carries the spurious vector |
| eoi | input | 1 | End-of-interrupt strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = task priority, 1 = spurious register |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data of the selected register |
| irq_out | output | 1 | Interrupt pending to the core |
| ppr | output | 8 | Processor priority |
| new_cnt | output | 16 | Count of newly delivered vectors |

## Verification
The bench targets the boundary where a request shares the class of the processor priority. In that case the interrupt line must stay low, yet an acknowledge of a vector just above the task priority must still be granted. A design that compares whole bytes, or classes on both paths, would raise the line or return the spurious vector there. The bench also sends a duplicate accept, an end-of-interrupt with nothing in service, and an acknowledge while disabled. A design that counted duplicates, corrupted the in-service set or consumed a request on a spurious reply would show a wrong count, a wrong `ppr` or a missing later grant. Both orderings of task class against in-service class are checked, so a processor priority taken from the wrong source is exposed.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    // Width of a priority class (upper part of a vector number)
    localparam int CLASS_W = 4;

    typedef enum logic {
        SEL_TASK = 1'b0,
        SEL_SPUR = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/vec_top_find.sv
module vec_top_find #(
    parameter int W = 256,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Highest-numbered set bit wins; later iterations overwrite earlier ones.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_class_calc.sv
module prio_class_calc #(
    parameter int VW = 8,
    localparam int CW = irq_prio_pkg::CLASS_W
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_hit,
    input  logic [VW-1:0] isr_top,
    output logic [VW-1:0] ppr
);
    logic [CW-1:0] tpr_cls;
    logic [CW-1:0] isr_cls;

    always_comb begin
        tpr_cls = tpr[VW-1 -: CW];
        isr_cls = isr_hit ? isr_top[VW-1 -: CW] : '0;
        if (tpr_cls >= isr_cls) ppr = tpr;
        else                    ppr = {isr_cls, {(VW-CW){1'b0}}};
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NVEC  = 256,
    parameter int CNT_W = 16,
    localparam int VW   = $clog2(NVEC),
    localparam int CW   = irq_prio_pkg::CLASS_W,
    localparam int SW   = VW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [VW-1:0] acc_vec,
    input  logic          acc_level,
    input  logic          ack_req,
    output logic          ack_valid,
    output logic [VW-1:0] ack_vec,
    output logic          ack_level,
    output logic          ack_spurious,
    input  logic          eoi,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [SW-1:0] reg_wdata,
    output logic [SW-1:0] reg_rdata,
    output logic          irq_out,
    output logic [VW-1:0] ppr,
    output logic [CNT_W-1:0] new_cnt
);
    import irq_prio_pkg::*;

    typedef struct packed {
        logic [NVEC-1:0]  irr;
        logic [NVEC-1:0]  isr;
        logic [NVEC-1:0]  tmr;
        logic [VW-1:0]    tpr;
        logic [SW-1:0]    spur;
        logic [CNT_W-1:0] cnt;
        logic             ack_valid;
        logic [VW-1:0]    ack_vec;
        logic             ack_level;
        logic             ack_spur;
    } state_t;

    state_t s_d, s_q;

    logic          irr_hit, isr_hit;
    logic [VW-1:0] irr_top, isr_top;
    logic          enabled;
    logic          ack_blocked;
    reg_sel_e      sel;

    vec_top_find #(.W(NVEC)) u_irr_find (.bits(s_q.irr), .hit(irr_hit), .idx(irr_top));
    vec_top_find #(.W(NVEC)) u_isr_find (.bits(s_q.isr), .hit(isr_hit), .idx(isr_top));

    prio_class_calc #(.VW(VW)) u_ppr (
        .tpr     (s_q.tpr),
        .isr_hit (isr_hit),
        .isr_top (isr_top),
        .ppr     (ppr)
    );

    assign enabled     = s_q.spur[VW];
    assign sel         = reg_sel_e'(reg_sel);
    assign ack_blocked = !enabled || !irr_hit ||
                         ((s_q.tpr != '0) && (irr_top <= s_q.tpr));

    always_comb begin
        s_d           = s_q;
        s_d.ack_valid = 1'b0;

        // retire highest in-service vector
        if (eoi && isr_hit)
            s_d.isr[isr_top] = 1'b0;

        // acknowledge: grant or spurious reply
        if (ack_req) begin
            s_d.ack_valid = 1'b1;
            if (ack_blocked) begin
                s_d.ack_vec   = s_q.spur[VW-1:0];
                s_d.ack_level = 1'b0;
                s_d.ack_spur  = 1'b1;
            end else begin
                s_d.irr[irr_top] = 1'b0;
                s_d.isr[irr_top] = 1'b1;
                s_d.ack_vec      = irr_top;
                s_d.ack_level    = s_q.tmr[irr_top];
                s_d.ack_spur     = 1'b0;
            end
        end

        // accept after grant so a same-cycle re-accept stays pending
        if (acc_valid) begin
            s_d.irr[acc_vec] = 1'b1;
            s_d.tmr[acc_vec] = acc_level;
            if (!s_q.irr[acc_vec])
                s_d.cnt = s_q.cnt + 1'b1;
        end

        if (reg_wr) begin
            if (sel == SEL_TASK)
                s_d.tpr = {reg_wdata[CW-1:0], {(VW-CW){1'b0}}};
            else
                s_d.spur = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.spur      <= SW'(NVEC - 1);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (sel == SEL_TASK) reg_rdata = SW'(s_q.tpr[VW-1 -: CW]);
        else                 reg_rdata = s_q.spur;
    end

    assign irq_out = enabled && irr_hit &&
                     ((ppr == '0) || (irr_top[VW-1 -: CW] > ppr[VW-1 -: CW]));

    assign ack_valid    = s_q.ack_valid;
    assign ack_vec      = s_q.ack_vec;
    assign ack_level    = s_q.ack_level;
    assign ack_spurious = s_q.ack_spur;
    assign new_cnt      = s_q.cnt;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> s_q.spur[VW]); // R3
    AST_IRQ_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (s_q.irr != '0)); // R4
    AST_ACK_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid); // R6
    AST_ACC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> s_q.irr[$past(acc_vec)]); // R1
    AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack_req && (s_q.isr == '0)) |=> (s_q.isr == '0)); // R7
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(new_cnt)); // R10
    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= s_q.tpr); // R9
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_level, ack_req, eoi, reg_wr, reg_sel;
    logic [7:0]  acc_vec;
    logic [8:0]  reg_wdata;
    logic        ack_valid, ack_level, ack_spurious, irq_out;
    logic [7:0]  ack_vec, ppr;
    logic [8:0]  reg_rdata;
    logic [15:0] new_cnt;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_vec(ack_vec),
        .ack_level(ack_level), .ack_spurious(ack_spurious),
        .eoi(eoi), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .ppr(ppr), .new_cnt(new_cnt)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        acc_valid = 0; ack_req = 0; eoi = 0; reg_wr = 0;
    endtask

    task automatic accept(input int v, input bit lvl);
        acc_valid = 1; acc_vec = 8'(v); acc_level = lvl;
        step();
    endtask

    task automatic wr(input bit s, input int d);
        reg_wr = 1; reg_sel = s; reg_wdata = 9'(d);
        step();
    endtask

    task automatic rd(input bit s, output int d);
        reg_sel = s; #0.5; d = int'(reg_rdata);
    endtask

    task automatic ack_expect(input string tag, input int v, input bit spur, input bit lvl);
        ack_req = 1;
        step();
        chk({tag, " ack_valid"}, int'(ack_valid), 1);
        chk({tag, " ack_vec"}, int'(ack_vec), v);
        chk({tag, " ack_spurious"}, int'(ack_spurious), int'(spur));
        if (!spur) chk({tag, " ack_level"}, int'(ack_level), int'(lvl));
    endtask

    task automatic end_intr();
        eoi = 1;
        step();
    endtask

    task automatic t_reset();
        int d;
        chk("R11 irq after reset", int'(irq_out), 0);
        chk("R11 ppr after reset", int'(ppr), 0);
        chk("R11 new_cnt after reset", int'(new_cnt), 0);
        rd(1, d); chk("R3 spurious reset value", d, 'h0FF);
        rd(0, d); chk("R11 task priority reset", d, 0);
    endtask

    task automatic t_disabled_accept();
        accept('h40, 1);
        chk("R10 first accept counts", int'(new_cnt), 1);
        chk("R3 disabled keeps irq low", int'(irq_out), 0);
        accept('h40, 1);
        chk("R10 duplicate not counted", int'(new_cnt), 1);
        accept('h90, 0);
        chk("R10 second vector counts", int'(new_cnt), 2);
        chk("R3 still disabled", int'(irq_out), 0);
    endtask

    task automatic t_enable();
        int d;
        wr(1, 'h3F5);
        rd(1, d); chk("R3 spurious write keeps 8:0", d, 'h1F5);
        chk("R4 irq with ppr zero", int'(irq_out), 1);
    endtask

    task automatic t_order();
        ack_expect("R2 R6 R1 highest edge", 'h90, 0, 0);
        chk("R9 ppr from in-service", int'(ppr), 'h90);
        chk("R4 lower class masked", int'(irq_out), 0);
        ack_expect("R6 R1 level vector", 'h40, 0, 1);
        chk("R9 ppr highest in-service", int'(ppr), 'h90);
        chk("R4 nothing pending", int'(irq_out), 0);
    endtask

    task automatic t_eoi();
        end_intr();
        chk("R7 eoi clears highest", int'(ppr), 'h40);
        end_intr();
        chk("R7 eoi clears next", int'(ppr), 0);
        end_intr();
        chk("R7 eoi on empty", int'(ppr), 0);
        ack_expect("R12 ack with nothing pending", 'hF5, 1, 0);
    endtask

    task automatic t_tpr();
        int d;
        wr(0, 5);
        rd(0, d); chk("R8 task priority readback", d, 5);
        chk("R8 R9 ppr from task", int'(ppr), 'h50);
        accept('h50, 0);
        chk("R10 count", int'(new_cnt), 3);
        chk("R4 same class not signalled", int'(irq_out), 0);
        ack_expect("R5 blocked at task priority", 'hF5, 1, 0);
        wr(0, 0);
        chk("R5 request kept after spurious", int'(irq_out), 1);
        ack_expect("R5 granted after task cleared", 'h50, 0, 0);
        accept('h50, 0);
        chk("R10 re-accept after grant counts", int'(new_cnt), 4);
        wr(0, 5);
        accept('h55, 1);
        chk("R10 count 0x55", int'(new_cnt), 5);
        chk("R4 class equal to ppr", int'(irq_out), 0);
        ack_expect("R5 above task priority granted", 'h55, 0, 1);
        chk("R9 task class equal in-service", int'(ppr), 'h50);
        wr(0, 7);
        chk("R9 task class above in-service", int'(ppr), 'h70);
        wr(0, 3);
        chk("R9 in-service class above task", int'(ppr), 'h50);
    endtask

    task automatic t_class();
        accept('h60, 0);
        chk("R10 count 0x60", int'(new_cnt), 6);
        chk("R4 higher class signalled", int'(irq_out), 1);
    endtask

    task automatic t_disable();
        wr(1, 'h0F5);
        chk("R3 clearing enable drops irq", int'(irq_out), 0);
        ack_expect("R12 ack while disabled", 'hF5, 1, 0);
        wr(1, 'h1F5);
        chk("R12 request survived disabled ack", int'(irq_out), 1);
        ack_expect("R2 R6 grant after re-enable", 'h60, 0, 0);
    endtask

    initial begin
        rst_n = 0; acc_valid = 0; acc_vec = 0; acc_level = 0; ack_req = 0;
        eoi = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_disabled_accept();
        t_enable();
        t_order();
        t_eoi();
        t_tpr();
        t_class();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule